// File: doc/BRIEF.md
# Privileged Segment Address Translation Buffer

This block translates addresses in two fixed privileged virtual windows into physical addresses. The windows are a cached window at virtual 0x80000000 to 0x9FFFFFFF and an uncached window at 0xA0000000 to 0xBFFFFFFF. Translation uses a small, fully associative table of large-page entries. Each entry carries a valid flag, a virtual page number, a physical page number, a two-bit page-size code and three attributes: cacheable, write-through and unbuffered write. Software fills the table only through an indexed register write port. No write path selects an entry by matching its virtual page.

A lookup presents a virtual address, a read/write flag and a user-mode flag. The block registers the request and resolves it from that register, so the result appears one cycle after the request is presented. The response falls into exactly one of four classes:

- **Hit:** translated address plus attributes.
- **Reset request:** a privileged access in a window matched no valid entry. The faulting address and event code 0x140 are captured.
- **Address error:** a user-mode access inside a window.
- **Bypass:** the address lies outside both windows.

Entries carry no protection field, so the access direction never changes a result. When several entries match, the lowest-numbered one wins and a multiple-hit flag is raised.

Top module: `pseg_xlat`

## Requirements
- R1: After reset every entry is invalid, `flt_addr` and `flt_code` read zero and `rsp_valid` is low, so a privileged lookup inside a window raises `rsp_rst_req`.
- R2: A write with `cfg_we` high loads the entry named by `cfg_idx`. The fields of `cfg_wdata` are: valid in bit 0, size code in [2:1], cacheable in bit 3, write-through in bit 4, unbuffered in bit 5, virtual page bits [31:24] in [15:8] and physical page bits [31:24] in [23:16]. A lookup presented on the cycle after the write uses the new contents.
- R3: Size codes 00, 01, 10 and 11 select 16, 64, 128 and 512 Mbyte pages. An entry matches when it is valid and virtual address bits [31:24], [31:26], [31:27] or [31:29] respectively equal the same bits of its virtual page.
- R4: On a hit, `rsp_paddr` takes the compared upper bits from the entry's physical page. The remaining bits come unchanged from the virtual address.
- R5: On a hit, `rsp_cache`, `rsp_wthru` and `rsp_unbuf` equal the chosen entry's cacheable, write-through and unbuffered bits.
- R6: A privileged lookup inside a window with no matching entry raises `rsp_rst_req`. On the next cycle `flt_addr` holds the virtual address and `flt_code` holds 0x140.
- R7: A user-mode lookup inside a window raises `rsp_addr_err` with no hit and no reset request, and leaves `flt_addr` and `flt_code` unchanged.
- R8: A lookup with virtual address bits [31:30] other than 10 raises `rsp_bypass`, returns the virtual address as `rsp_paddr` and leaves the fault registers unchanged.
- R9: `req_write` has no effect on any response output.
- R10: When several valid entries match, the lowest-numbered one supplies the translation and `rsp_multi` is high. `rsp_multi` is low when exactly one entry matches.
- R11: `rsp_valid` is high in the cycle after `req_valid` was sampled high and low otherwise. All class flags and attributes are low while `rsp_valid` is low.
- R12: While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_rst_req`, `rsp_addr_err` and `rsp_bypass` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_wdata | input | 32 | Packed entry fields |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access direction (no effect) |
| req_user | input | 1 | User-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_hit | output | 1 | Translation found |
| rsp_cache | output | 1 | Cacheable attribute |
| rsp_wthru | output | 1 | Write-through attribute |
| rsp_unbuf | output | 1 | Unbuffered-write attribute |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_bypass | output | 1 | Address outside both windows |
| rsp_addr_err | output | 1 | User access to a window |
| rsp_rst_req | output | 1 | Miss, reset requested |
| flt_addr | output | 32 | Captured faulting address |
| flt_code | output | EVT_W | Captured event code |

## Verification
The bench drives a request on a falling edge; the request register captures it at the following rising edge. Every response output is therefore read at the next falling edge, one cycle after the stimulus. The fault registers load on the rising edge after a reset-request response, so they are read one falling edge later still, which is also where `rsp_valid` is confirmed low again. Table writes are followed directly by a lookup on the next cycle, which exercises write-to-lookup visibility with no idle cycle between them.

// File: rtl/pseg_pkg.sv
package pseg_pkg;

   localparam int VA_W = 32;
   localparam int PN_W = 8;

   typedef enum logic [1:0] {
      SZ_16M  = 2'b00,
      SZ_64M  = 2'b01,
      SZ_128M = 2'b10,
      SZ_512M = 2'b11
   } pg_size_e;

   typedef struct packed {
      logic           vld;
      pg_size_e       size;
      logic           cach;
      logic           wthru;
      logic           unbuf;
      logic [PN_W-1:0] vpn;
      logic [PN_W-1:0] ppn;
   } xent_t;

   // upper-bit compare mask for each page size
   function automatic logic [PN_W-1:0] size_mask(pg_size_e s);
      case (s)
         SZ_16M:  return 8'hFF;
         SZ_64M:  return 8'hFC;
         SZ_128M: return 8'hF8;
         default: return 8'hE0;
      endcase
   endfunction

endpackage

// File: rtl/pseg_entry_bank.sv
module pseg_entry_bank
   import pseg_pkg::*;
#(
   parameter int NUM_ENT = 16,
   localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          widx,
   input  logic [31:0]               wdata,
   output xent_t [NUM_ENT-1:0]       ents
);

   xent_t                 wr_ent;
   logic [NUM_ENT-1:0]    vld_vec;
   logic [9:0]            wdata_unused;

   assign wdata_unused = {wdata[31:24], wdata[7:6]};

   always_comb begin
      wr_ent       = '0;
      wr_ent.vld   = wdata[0];
      wr_ent.size  = pg_size_e'(wdata[2:1]);
      wr_ent.cach  = wdata[3];
      wr_ent.wthru = wdata[4];
      wr_ent.unbuf = wdata[5];
      wr_ent.vpn   = wdata[15:8];
      wr_ent.ppn   = wdata[23:16];
   end

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ents[i] <= '0;
         else if (we && (widx == IDX_W'(i)))
            ents[i] <= wr_ent;
      end
      assign vld_vec[i] = ents[i].vld;
   end

   // R1: reset leaves no valid entry behind
   p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> (vld_vec == '0));

endmodule

// File: rtl/pseg_match.sv
module pseg_match
   import pseg_pkg::*;
#(
   parameter int NUM_ENT = 16
) (
   input  xent_t [NUM_ENT-1:0] ents,
   input  logic [PN_W-1:0]     va_hi,
   output logic [NUM_ENT-1:0]  hits
);

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
      logic [PN_W-1:0] msk;
      assign msk     = size_mask(ents[i].size);
      assign hits[i] = ents[i].vld && ((va_hi & msk) == (ents[i].vpn & msk));
   end

endmodule

// File: rtl/pseg_prio_sel.sv
module pseg_prio_sel #(
   parameter int NUM_ENT = 16,
   localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ENT-1:0]  hits,
   output logic [IDX_W-1:0]    sel,
   output logic                any,
   output logic                multi
);

   always_comb begin
      sel = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (hits[i]) sel = IDX_W'(i);
      end
   end

   assign any   = |hits;
   assign multi = ($countones(hits) > 1);

   // R10: selected entry matches and no lower entry does
   p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (hits[sel] && ((hits & ((NUM_ENT'(1) << sel) - NUM_ENT'(1))) == '0)));
   p_multi_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      multi |-> any);

endmodule

// File: rtl/pseg_xlat.sv
module pseg_xlat
   import pseg_pkg::*;
#(
   parameter int          NUM_ENT  = 16,
   parameter int          EVT_W    = 12,
   parameter logic [11:0] EVT_MISS = 12'h140,
   localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [31:0]      cfg_wdata,
   input  logic             req_valid,
   input  logic [31:0]      req_vaddr,
   input  logic             req_write,
   input  logic             req_user,
   output logic             rsp_valid,
   output logic [31:0]      rsp_paddr,
   output logic             rsp_hit,
   output logic             rsp_cache,
   output logic             rsp_wthru,
   output logic             rsp_unbuf,
   output logic             rsp_multi,
   output logic             rsp_bypass,
   output logic             rsp_addr_err,
   output logic             rsp_rst_req,
   output logic [31:0]      flt_addr,
   output logic [EVT_W-1:0] flt_code
);

   localparam int LOW_W = VA_W - PN_W;

   if (NUM_ENT < 2 || NUM_ENT > 64) begin : g_bad_ent
      $error("pseg_xlat: NUM_ENT must lie in 2..64");
   end
   if (EVT_W < 9 || EVT_W > 12) begin : g_bad_evt
      $error("pseg_xlat: EVT_W must lie in 9..12");
   end

   xent_t [NUM_ENT-1:0] ents;
   logic [NUM_ENT-1:0]  hits;
   logic [IDX_W-1:0]    sel;
   logic                any_hit, multi_hit;
   logic                rq_vld, rq_user;
   logic [31:0]         rq_va;
   logic                in_win;
   logic [PN_W-1:0]     msk;
   logic                dir_unused;

   assign dir_unused = req_write;

   pseg_entry_bank #(.NUM_ENT(NUM_ENT)) i_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx),
      .wdata(cfg_wdata), .ents(ents)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rq_vld  <= 1'b0;
         rq_va   <= '0;
         rq_user <= 1'b0;
      end else begin
         rq_vld <= req_valid;
         if (req_valid) begin
            rq_va   <= req_vaddr;
            rq_user <= req_user;
         end
      end
   end

   pseg_match #(.NUM_ENT(NUM_ENT)) i_match (
      .ents(ents), .va_hi(rq_va[VA_W-1 -: PN_W]), .hits(hits)
   );

   pseg_prio_sel #(.NUM_ENT(NUM_ENT)) i_sel (
      .clk(clk), .rst_n(rst_n), .hits(hits), .sel(sel),
      .any(any_hit), .multi(multi_hit)
   );

   assign in_win = (rq_va[31:30] == 2'b10);
   assign msk    = size_mask(ents[sel].size);

   always_comb begin
      rsp_valid    = rq_vld;
      rsp_paddr    = rq_va;
      rsp_hit      = 1'b0;
      rsp_cache    = 1'b0;
      rsp_wthru    = 1'b0;
      rsp_unbuf    = 1'b0;
      rsp_multi    = 1'b0;
      rsp_bypass   = 1'b0;
      rsp_addr_err = 1'b0;
      rsp_rst_req  = 1'b0;
      if (rq_vld) begin
         if (!in_win)
            rsp_bypass = 1'b1;
         else if (rq_user)
            rsp_addr_err = 1'b1;
         else if (any_hit) begin
            rsp_hit   = 1'b1;
            rsp_paddr = {(ents[sel].ppn & msk) | (rq_va[VA_W-1 -: PN_W] & ~msk),
                         rq_va[LOW_W-1:0]};
            rsp_cache = ents[sel].cach;
            rsp_wthru = ents[sel].wthru;
            rsp_unbuf = ents[sel].unbuf;
            rsp_multi = multi_hit;
         end else
            rsp_rst_req = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_addr <= '0;
         flt_code <= '0;
      end else if (rsp_rst_req) begin
         flt_addr <= rq_va;
         flt_code <= EVT_MISS[EVT_W-1:0];
      end
   end

   // R12: one outcome class per response
   p_one_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_hit, rsp_rst_req, rsp_addr_err, rsp_bypass}) == 1));
   // R11: response follows request by one cycle, quiet otherwise
   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit | rsp_cache | rsp_wthru | rsp_unbuf | rsp_multi |
                       rsp_bypass | rsp_addr_err | rsp_rst_req));
   // R6: fault capture one cycle after a reset request
   p_fault_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rst_req |=> (flt_addr == $past(rq_va)) && (flt_code == EVT_MISS[EVT_W-1:0]));
   // R7: user access keeps fault registers
   p_user_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_addr_err |=> $stable(flt_addr) && $stable(flt_code));
   // R4: offset bits always pass straight through
   p_low_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_paddr[LOW_W-1:0] == rq_va[LOW_W-1:0]));

endmodule

// File: tb/test_pseg_xlat.sv
`timescale 1ns/1ps
module test_pseg_xlat;

   localparam int NE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_cache, rsp_wthru, rsp_unbuf, rsp_multi;
   logic        rsp_bypass, rsp_addr_err, rsp_rst_req;
   logic [31:0] rsp_paddr, flt_addr;
   logic [11:0] flt_code;

   int n_cmp = 0;
   int n_bad = 0;

   logic        m_vld [NE];
   logic [1:0]  m_sz  [NE];
   logic [2:0]  m_att [NE];
   logic [7:0]  m_vpn [NE];
   logic [7:0]  m_ppn [NE];
   logic [31:0] e_faddr = '0;
   logic [11:0] e_fcode = '0;

   always #2 clk = ~clk;

   pseg_xlat i_pseg_xlat (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_cache(rsp_cache),
      .rsp_wthru(rsp_wthru), .rsp_unbuf(rsp_unbuf), .rsp_multi(rsp_multi),
      .rsp_bypass(rsp_bypass), .rsp_addr_err(rsp_addr_err), .rsp_rst_req(rsp_rst_req),
      .flt_addr(flt_addr), .flt_code(flt_code)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mask_of(logic [1:0] s);
      int sh;
      sh = (s == 2'd0) ? 0 : (s == 2'd1) ? 2 : (s == 2'd2) ? 3 : 5;
      return 8'hFF << sh;
   endfunction

   // R2: write one entry, field layout from the requirement
   task automatic wr_ent(int idx, bit v, logic [1:0] sz, logic [2:0] att,
                         logic [7:0] vpn, logic [7:0] ppn);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_idx   = 4'(idx);
      cfg_wdata = {8'hC3, ppn, vpn, 2'b11, att, sz, v};
      @(negedge clk);
      cfg_we = 1'b0;
      m_vld[idx] = v; m_sz[idx] = sz; m_att[idx] = att;
      m_vpn[idx] = vpn; m_ppn[idx] = ppn;
   endtask

   logic [31:0] last_pa;
   logic [3:0]  last_att;

   task automatic look(logic [31:0] va, bit user, bit wr);
      int   first, cnt;
      bit   in_win;
      logic [7:0]  msk;
      logic [31:0] e_pa;
      logic [3:0]  e_cls;
      first = -1; cnt = 0;
      in_win = (va[31:30] == 2'b10);
      for (int i = 0; i < NE; i++) begin
         if (m_vld[i] && ((va[31:24] & mask_of(m_sz[i])) == (m_vpn[i] & mask_of(m_sz[i])))) begin
            cnt++;
            if (first < 0) first = i;
         end
      end
      req_valid = 1'b1; req_vaddr = va; req_user = user; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 valid", 64'(rsp_valid), 64'd1);
      if (!in_win) begin
         chk("R8 class", 64'({rsp_hit, rsp_rst_req, rsp_addr_err, rsp_bypass}), 64'b0001);
         chk("R8 paddr", 64'(rsp_paddr), 64'(va));
      end else if (user) begin
         chk("R7 class", 64'({rsp_hit, rsp_rst_req, rsp_addr_err, rsp_bypass}), 64'b0010);
      end else if (first < 0) begin
         chk("R6 class", 64'({rsp_hit, rsp_rst_req, rsp_addr_err, rsp_bypass}), 64'b0100);
         e_faddr = va; e_fcode = 12'h140;
      end else begin
         msk  = mask_of(m_sz[first]);
         e_pa = {(m_ppn[first] & msk) | (va[31:24] & ~msk), va[23:0]};
         chk("R3 class", 64'({rsp_hit, rsp_rst_req, rsp_addr_err, rsp_bypass}), 64'b1000);
         chk("R4 paddr", 64'(rsp_paddr), 64'(e_pa));
         chk("R5 attrs", 64'({rsp_unbuf, rsp_wthru, rsp_cache}), 64'(m_att[first]));
         chk("R10 multi", 64'(rsp_multi), 64'(cnt > 1));
      end
      last_pa  = rsp_paddr;
      last_att = {rsp_multi, rsp_unbuf, rsp_wthru, rsp_cache};
      @(negedge clk);
      chk("R11 idle", 64'({rsp_valid, rsp_hit, rsp_rst_req, rsp_addr_err, rsp_bypass}), 64'd0);
      chk(in_win ? (user ? "R7 fault" : "R6 fault") : "R8 fault",
          {20'd0, flt_code, flt_addr}, {20'd0, e_fcode, e_faddr});
   endtask

   task automatic sweep();
      logic [31:0] va, pa0;
      logic [3:0]  at0;
      for (int h = 0; h < 256; h++) begin
         va = {8'(h), 24'((h * 24'h010101) ^ 24'h5A5A5A)};
         look(va, 1'b0, 1'b0);
         pa0 = last_pa; at0 = last_att;
         look(va, 1'b0, 1'b1);
         chk("R9 dir", {28'd0, last_att, last_pa}, {28'd0, at0, pa0});
         look(va, 1'b1, h[0]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_vld[i] = 0; m_sz[i] = 0; m_att[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk("R1 rst", {31'd0, rsp_valid, flt_addr}, 64'd0);
      chk("R1 code", 64'(flt_code), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty table, every privileged window lookup misses
      look(32'h8123_4567, 1'b0, 1'b0);
      look(32'hBFFF_FFFC, 1'b0, 1'b1);
      sweep();
      // disjoint table: sizes 16M/64M/128M, one invalid entry
      for (int i = 0; i < NE; i++)
         wr_ent(i, i != 6, 2'(i % 3), 3'(i), 8'(8'h80 + 8 * i), 8'(8'h11 * i + 3));
      sweep();
      // overlapping table with 512M pages to force multiple hits
      for (int i = 0; i < NE; i++)
         wr_ent(i, 1'b1, 2'(i / 4), 3'(7 - (i % 8)), 8'(8'h80 + ((i * 5) & 8'h3F)),
                8'(8'hF0 - 8'h0D * i));
      sweep();
      // R2: lookup in the cycle right after a rewrite sees the new entry
      wr_ent(0, 1'b1, 2'd3, 3'b101, 8'hA0, 8'h40);
      look(32'hA765_4321, 1'b0, 1'b0);
      chk("R2 paddr", 64'(rsp_paddr), 64'(32'hA765_4321));
      wr_ent(0, 1'b1, 2'd3, 3'b010, 8'hA0, 8'h60);
      look(32'hA765_4321, 1'b0, 1'b0);
      chk("R2 new", 64'(last_pa), 64'(32'h6765_4321));
      wr_ent(0, 1'b0, 2'd3, 3'b000, 8'hA0, 8'h60);
      look(32'hA765_4321, 1'b0, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule